// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides, for a small processor subsystem, which clock domains keep running while the core sleeps. Software arms a sleep-enable bit and picks one of six sleep modes with a 3-bit selector. A sleep request then moves the controller out of its running state. It drops the clock-enable outputs of every domain that the chosen mode stops. The domains are the CPU, memory access, general I/O peripherals, the ADC, the asynchronous timer and the main oscillator. The enables of the surviving domains stay high.

While asleep, the block watches four wake inputs and accepts only those that the latched mode allows. Some modes stop the oscillator. When one of them is left, every enable is held low for a start-up window of `STARTUP_CYC` cycles, so the oscillator can settle before the domains restart. Reset is active low and asynchronous.

The controller has three states:
- AWAKE: everything runs.
- ASLEEP: only the mode's survivors run.
- OSC_WAIT: all enables are low while the start-up window counts.

It has four transitions:
- ENTER, from AWAKE to ASLEEP, on `sleep_req` with `sleep_en`.
- RESUME, from ASLEEP to AWAKE, on an allowed wake when the oscillator was kept.
- RESTART, from ASLEEP to OSC_WAIT, on an allowed wake when the oscillator was stopped.
- RELEASE, from OSC_WAIT to AWAKE, when the window expires.

Top module: `nap_ctrl`

## Requirements
- R1: Out of reset, and whenever AWAKE, `dom_en` is 6'b111111 with `sleeping`=0 and `osc_wait`=0.
- R2: `sleep_req` has no effect unless `sleep_en` is 1. ENTER happens at the first clock edge that sees both inputs high. The mode is sampled at that edge and held until wake-up; later changes of `mode_sel` are ignored.
- R3: `dom_en` bit order is [0] CPU, [1] memory, [2] I/O, [3] ADC, [4] async timer, [5] oscillator. Mode 0 (idle) keeps 6'b111100.
- R4: Mode 1 (ADC quiet) keeps 6'b111000.
- R5: Mode 2 (deep) keeps 6'b000000 and wakes only on `ext_irq`.
- R6: Mode 3 (deep with timer) keeps 6'b010000 and wakes on `ext_irq` or `atmr_evt`.
- R7: Mode 6 (standby) keeps 6'b100000. It wakes on `ext_irq` straight to AWAKE, with no start-up window.
- R8: Mode 7 (extended standby) keeps 6'b110000. It wakes on `ext_irq` or `atmr_evt` straight to AWAKE.
- R9: Waking from mode 2 or 3 drives `osc_wait`=1 and `dom_en`=0 for exactly `STARTUP_CYC` cycles, then returns to AWAKE.
- R10: The unused encodings 4 and 5 behave exactly as mode 0.
- R11: Wake sources differ by mode:
  - Idle wakes on any of `irq_any`, `adc_done`, `atmr_evt` and `ext_irq`.
  - ADC quiet wakes on all of these except `irq_any`.
  - A source that the latched mode does not allow leaves the block asleep with unchanged enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Arms sleep entry |
| sleep_req | input | 1 | Request to enter sleep |
| mode_sel | input | 3 | Sleep mode encoding |
| irq_any | input | 1 | Any enabled interrupt pending |
| adc_done | input | 1 | ADC conversion-complete event |
| atmr_evt | input | 1 | Asynchronous timer event |
| ext_irq | input | 1 | External interrupt |
| dom_en | output | 6 | Clock enable per domain |
| sleeping | output | 1 | High in ASLEEP |
| osc_wait | output | 1 | High during the oscillator start-up window |

## Verification
Every output comes straight from the state register. The effect of a request or wake input applied before an edge is therefore visible one clock edge later, and the RELEASE edge comes `STARTUP_CYC` edges after RESTART. The driver applies one stimulus per cycle at the falling edge and queues the outcome due after the next rising edge. The monitor pops and compares one entry shortly after each rising edge, so every expectation is checked at exactly that one-edge latency, and the start-up window is checked cycle by cycle.

// File: rtl/nap_pkg.sv
package nap_pkg;
    localparam int DOM_N  = 6;
    localparam int WAKE_N = 4;

    // domain bit positions in dom_en
    localparam int D_CPU  = 0;
    localparam int D_MEM  = 1;
    localparam int D_IO   = 2;
    localparam int D_ADC  = 3;
    localparam int D_ATMR = 4;
    localparam int D_OSC  = 5;

    // wake source bit positions
    localparam int W_IRQ  = 0;
    localparam int W_ADC  = 1;
    localparam int W_ATMR = 2;
    localparam int W_EXT  = 3;

    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_ADCQ  = 3'd1,
        M_DEEP  = 3'd2,
        M_DEEPT = 3'd3,
        M_RSV4  = 3'd4,
        M_RSV5  = 3'd5,
        M_STBY  = 3'd6,
        M_XSTBY = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        S_AWAKE    = 2'd0,
        S_ASLEEP   = 2'd1,
        S_OSC_WAIT = 2'd2
    } state_e;

    // reserved encodings fold onto idle (R10)
    function automatic mode_e norm_mode(input logic [2:0] m);
        if (m == 3'd4 || m == 3'd5) return M_IDLE;
        return mode_e'(m);
    endfunction
endpackage

// File: rtl/nap_domain_map.sv
module nap_domain_map
    import nap_pkg::*;
#(
    parameter int N = DOM_N
) (
    input  mode_e          mode,
    output logic [N-1:0]   keep
);
    always_comb begin
        keep = '0;
        unique case (mode)
            M_IDLE, M_RSV4, M_RSV5: begin
                keep[D_IO] = 1'b1; keep[D_ADC] = 1'b1;
                keep[D_ATMR] = 1'b1; keep[D_OSC] = 1'b1;
            end
            M_ADCQ: begin
                keep[D_ADC] = 1'b1; keep[D_ATMR] = 1'b1; keep[D_OSC] = 1'b1;
            end
            M_DEEP:  keep = '0;
            M_DEEPT: keep[D_ATMR] = 1'b1;
            M_STBY:  keep[D_OSC] = 1'b1;
            M_XSTBY: begin
                keep[D_ATMR] = 1'b1; keep[D_OSC] = 1'b1;
            end
            default: keep = '0;
        endcase
    end
endmodule

// File: rtl/nap_wake_filter.sv
module nap_wake_filter
    import nap_pkg::*;
#(
    parameter int N = WAKE_N
) (
    input  mode_e        mode,
    input  logic [N-1:0] src,
    output logic         hit
);
    logic [N-1:0] allow;
    logic [N-1:0] qual;

    always_comb begin
        allow = '0;
        allow[W_EXT] = 1'b1;              // external interrupt wakes every mode
        unique case (mode)
            M_IDLE, M_RSV4, M_RSV5: allow = '1;
            M_ADCQ: begin
                allow[W_ADC] = 1'b1; allow[W_ATMR] = 1'b1;
            end
            M_DEEPT, M_XSTBY: allow[W_ATMR] = 1'b1;
            M_DEEP, M_STBY: ;
            default: ;
        endcase
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_qual
        assign qual[gi] = src[gi] & allow[gi];
    end

    assign hit = |qual;
endmodule

// File: rtl/nap_osc_timer.sv
module nap_osc_timer #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + CW'(1);
        else          cnt <= '0;
    end

    assign done = run && (cnt == CW'(CYC - 1));

    // R9: the count never passes the window length
    a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CW'(CYC)));
endmodule

// File: rtl/nap_ctrl.sv
module nap_ctrl
    import nap_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_en,
    input  logic                 sleep_req,
    input  logic [2:0]           mode_sel,
    input  logic                 irq_any,
    input  logic                 adc_done,
    input  logic                 atmr_evt,
    input  logic                 ext_irq,
    output logic [DOM_N-1:0]     dom_en,
    output logic                 sleeping,
    output logic                 osc_wait
);
    state_e            state, state_nx;
    mode_e             mode_q;
    logic [DOM_N-1:0]  keep;
    logic [WAKE_N-1:0] src;
    logic              wake_hit;
    logic              tmr_done;
    logic              enter;

    assign src   = {ext_irq, atmr_evt, adc_done, irq_any};
    assign enter = (state == S_AWAKE) && sleep_en && sleep_req;

    nap_domain_map #(.N(DOM_N)) u_map (.mode(mode_q), .keep(keep));
    nap_wake_filter #(.N(WAKE_N)) u_wake (.mode(mode_q), .src(src), .hit(wake_hit));
    nap_osc_timer #(.CYC(STARTUP_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == S_OSC_WAIT), .done(tmr_done));

    // state register and latched mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_AWAKE;
            mode_q <= M_IDLE;
        end else begin
            state <= state_nx;
            if (enter) mode_q <= norm_mode(mode_sel);
        end
    end

    // transitions: ENTER, RESUME, RESTART, RELEASE
    always_comb begin
        state_nx = state;
        unique case (state)
            S_AWAKE:    if (enter) state_nx = S_ASLEEP;
            S_ASLEEP:   if (wake_hit) state_nx = keep[D_OSC] ? S_AWAKE : S_OSC_WAIT;
            S_OSC_WAIT: if (tmr_done) state_nx = S_AWAKE;
            default:    state_nx = S_AWAKE;
        endcase
    end

    // outputs
    always_comb begin
        dom_en   = '1;
        sleeping = 1'b0;
        osc_wait = 1'b0;
        unique case (state)
            S_AWAKE:    dom_en = '1;
            S_ASLEEP:   begin dom_en = keep; sleeping = 1'b1; end
            S_OSC_WAIT: begin dom_en = '0; osc_wait = 1'b1; end
            default:    dom_en = '1;
        endcase
    end

    // R1: staying awake keeps every domain on
    a_r1_awake_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AWAKE && !(sleep_en && sleep_req)) |=> (dom_en == '1 && !sleeping));
    // R2: no entry without the enable bit
    a_r2_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AWAKE && !sleep_en) |=> (state == S_AWAKE));
    // R5: deep mode ignores everything but the external interrupt
    a_r5_deep_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && mode_q == M_DEEP && !ext_irq) |=> sleeping);
    // R7: standby resumes without a start-up window
    a_r7_standby_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && mode_q == M_STBY && ext_irq) |=> (!sleeping && !osc_wait && dom_en == '1));
    // R9: the window holds until the timer expires
    a_r9_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OSC_WAIT && !tmr_done) |=> (osc_wait && dom_en == '0));
endmodule

// File: tb/nap_ctrl_test.sv
module nap_ctrl_test;
    localparam int STARTUP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_en = 1'b0, sleep_req = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic irq_any = 1'b0, adc_done = 1'b0, atmr_evt = 1'b0, ext_irq = 1'b0;
    logic [5:0] dom_en;
    logic sleeping, osc_wait;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] q_val[$];
    string      q_tag[$];
    logic [7:0] e_val, g_val;
    string      e_tag;

    always #4 clk = ~clk;   // 125 MHz

    nap_ctrl #(.STARTUP_CYC(STARTUP)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_req(sleep_req),
        .mode_sel(mode_sel), .irq_any(irq_any), .adc_done(adc_done),
        .atmr_evt(atmr_evt), .ext_irq(ext_irq),
        .dom_en(dom_en), .sleeping(sleeping), .osc_wait(osc_wait));

    // expected survivor set per mode, bit order R3: cpu,mem,io,adc,atmr,osc
    function automatic logic [5:0] keep_of(input logic [2:0] m);
        case (m)
            3'd1: return 6'b111000;   // R4
            3'd2: return 6'b000000;   // R5
            3'd3: return 6'b010000;   // R6
            3'd6: return 6'b100000;   // R7
            3'd7: return 6'b110000;   // R8
            default: return 6'b111100; // R3, R10
        endcase
    endfunction

    // allowed wake sources {ext, atmr, adc, irq}, R11
    function automatic logic [3:0] allow_of(input logic [2:0] m);
        case (m)
            3'd1: return 4'b1110;
            3'd2, 3'd6: return 4'b1000;
            3'd3, 3'd7: return 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R3 idle survivors";
            3'd1: return "R4 adc quiet survivors";
            3'd2: return "R5 deep survivors";
            3'd3: return "R6 deep timer survivors";
            3'd6: return "R7 standby survivors";
            3'd7: return "R8 ext standby survivors";
            default: return "R10 reserved as idle";
        endcase
    endfunction

    // driver: apply one stimulus and queue what is due after the next edge
    task automatic step(input logic en, input logic req, input logic [2:0] m,
                        input logic [3:0] s, input logic [5:0] dom,
                        input logic slp, input logic wt, input string tag);
        @(negedge clk);
        sleep_en = en; sleep_req = req; mode_sel = m;
        {ext_irq, atmr_evt, adc_done, irq_any} = s;
        q_val.push_back({dom, slp, wt});
        q_tag.push_back(tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (q_val.size() > 0) begin
            e_val = q_val.pop_front();
            e_tag = q_tag.pop_front();
            g_val = {dom_en, sleeping, osc_wait};
            checks++;
            if (g_val !== e_val) begin
                errors++;
                $display("FAIL %s: actual dom=%b slp=%b wait=%b expected dom=%b slp=%b wait=%b",
                         e_tag, g_val[7:2], g_val[1], g_val[0], e_val[7:2], e_val[1], e_val[0]);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog R1: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 3'd0, 4'b0000, 6'h3f, 0, 0, "R1 reset state");
        for (int m = 0; m < 8; m++) begin
            logic [2:0] mm;
            logic [3:0] al;
            int w;
            mm = 3'(m);
            al = allow_of(mm);
            // R2: request without enable is ignored
            step(0, 1, mm, 4'b0000, 6'h3f, 0, 0, "R2 ignored without enable");
            step(1, 1, mm, 4'b0000, keep_of(mm), 1, 0, req_of(mm));
            // R11: disallowed sources keep it asleep; mode_sel changed to show R2 latching
            for (int s = 0; s < 4; s++) begin
                if (!al[s])
                    step(1, 0, ~mm, 4'(1 << s), keep_of(mm), 1, 0, "R11 rejected source");
            end
            step(1, 0, ~mm, 4'b0000, keep_of(mm), 1, 0, "R2 mode held while asleep");
            w = 3;
            for (int s = 3; s >= 0; s--) if (al[s]) w = s;
            if (mm == 3'd2 || mm == 3'd3) begin
                step(1, 0, mm, 4'(1 << w), 6'h00, 0, 1, "R9 start-up window");
                for (int k = 1; k < STARTUP; k++)
                    step(1, 0, mm, 4'b0000, 6'h00, 0, 1, "R9 start-up window");
                step(0, 0, mm, 4'b0000, 6'h3f, 0, 0, "R9 release to awake");
            end else begin
                step(0, 0, mm, 4'(1 << w), 6'h3f, 0, 0, "R11 accepted wake");
            end
            step(0, 0, mm, 4'b0000, 6'h3f, 0, 0, "R1 awake after wake");
        end
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule